// File: doc/BRIEF.md
# Retrying SPI byte master

This block is the master end of a framed serial link toward a slave that applies flow control one byte at a time. A local client hands over one request at a time on a valid/ready pair: either a byte to write or a request to read a byte. The block generates the serial clock, an active-low chip select and the outgoing data line. It samples the incoming data line and, at the end of every frame, reads one status bit from the slave.

A frame has 13 serial clock cycles with chip select held low throughout. A status of 1 means the slave rejected a written byte or had only stale data for a read. In either case the block repeats the identical frame. A status of 0 completes the request. Read data reaches the client only from a frame whose status was 0. An optional limit on re-issues turns an endless retry loop into a dropped request that is flagged as an error.

Top module: `spi_retry_master`

## Requirements
- R1: After reset, `cs_n` = 1, `sdi` = 1, `sclk` = 0, `req_ready` = 1 and `done` = 0.
- R2: Each frame has exactly 13 rising `sclk` edges while `cs_n` is low. The slave sees the bits in this order on those edges:
  - edge 1: a start bit of 1;
  - edge 2: a direction bit, 1 for read and 0 for write;
  - edge 3: a select bit of 0;
  - edges 4 to 11: eight data bits, most significant first;
  - edge 12: the status bit from the slave;
  - edge 13: a closing cycle.
- R3: Each half period of `sclk` lasts `clk_div`+1 system clocks. `sdi` changes only while `sclk` is low, so it changes on falling edges or while idle.
- R4: The status bit is the value of `sdo` that the slave drives after rising edge 12 of the frame. The block samples it before rising edge 13. On a read, the data bits are the values of `sdo` that follow rising edges 4 to 11.
- R5: On a write with status 1, the same byte is sent again in a new frame with identical content.
- R6: On a write with status 0, `done` pulses for one cycle with `done_err` = 0, and the block returns to idle with `cs_n` high and `sclk` low.
- R7: On a read, frames repeat while the status is 1. `rd_data` changes only when `done` pulses after a status of 0, and it then holds the byte from that frame. Stale bytes are never delivered.
- R8: Between frames, and whenever `cs_n` is high, `sdi` is 1. At least one rising `sclk` edge occurs with `cs_n` high before the next frame starts.
- R9: When `retry_max` is nonzero and the frame after `retry_max` re-issues still returns status 1, the request is dropped. `done` and `done_err` pulse together and no further frame follows. When `retry_max` is 0, retries are unlimited.
- R10: `req_ready` is low from acceptance until completion. In particular it is low whenever `cs_n` is low or `sclk` is high.
- R11: `done` rises exactly 28·F·(`clk_div`+1) system clocks after the clock edge that accepts the request, where F is the number of frames sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIVW | Half period of `sclk` in system clocks, minus one |
| retry_max | input | RETW | Maximum number of re-issues; 0 means unlimited |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_read | input | 1 | 1 for a read request, 0 for a write request |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle pulse when a request finishes |
| done_err | output | 1 | Set with `done` when the request was dropped at the retry limit |
| rd_data | output | 8 | Last byte read with fresh status |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| sdi | output | 1 | Serial data from the master to the slave |
| sdo | input | 1 | Serial data and status from the slave to the master |

## Verification
The bound checker watches the following on every cycle:
- `sdi` stays high whenever chip select is high;
- `sdi` changes only while `sclk` is low;
- the block is never ready while a frame is running;
- the error flag appears only together with `done`;
- completion leaves the lines idle.

Some behaviours show only in the bench's scenarios, which drive a slave model that rejects a chosen number of frames. These are the bit order and frame length, the identical content of repeated frames, the suppression of stale read bytes, the exact retry limit and the completion latency. The scenarios sweep divider values, retry limits, reject counts and both directions.

// File: rtl/spi_retry_master.sv
module spi_retry_master #(
  parameter int DIVW = 8,
  parameter int RETW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] clk_div,
  input  logic [RETW-1:0] retry_max,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_read,
  input  logic [7:0]      req_wdata,
  output logic            done,
  output logic            done_err,
  output logic [7:0]      rd_data,
  output logic            sclk,
  output logic            cs_n,
  output logic            sdi,
  input  logic            sdo
);
  localparam logic [3:0] DATA_FIRST = 4'd3;
  localparam logic [3:0] DATA_LAST  = 4'd10;
  localparam logic [3:0] STAT_BIT   = 4'd11;
  localparam logic [3:0] CLOSE_BIT  = 4'd12;
  localparam logic [3:0] GAP_BIT    = 4'd13;

  logic            busy, is_rd, stat;
  logic [7:0]      wbyte, rxsh;
  logic [3:0]      cnt;
  logic [DIVW-1:0] divc;
  logic [RETW-1:0] retries;
  logic            tick;

  assign req_ready = !busy;
  assign tick      = busy && (divc == clk_div);

  function automatic logic bit_for(input logic [3:0] n, input logic rd, input logic [7:0] b);
    if (n == 4'd1) return rd;
    if (n == 4'd2) return 1'b0;
    if (n >= DATA_FIRST && n <= DATA_LAST) return b[3'(DATA_LAST - n)];
    return 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; is_rd <= 1'b0; stat <= 1'b0;
      wbyte <= '0; rxsh <= '0; rd_data <= '0;
      cnt <= '0; divc <= '0; retries <= '0;
      sclk <= 1'b0; cs_n <= 1'b1; sdi <= 1'b1;
      done <= 1'b0; done_err <= 1'b0;
    end else begin
      done <= 1'b0;
      done_err <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy <= 1'b1; is_rd <= req_read; wbyte <= req_wdata;
          cnt <= '0; divc <= '0; retries <= '0;
          cs_n <= 1'b0; sdi <= 1'b1; sclk <= 1'b0;
        end
      end else if (!tick) begin
        divc <= divc + 1'b1;
      end else begin
        divc <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (cnt >= DATA_FIRST && cnt <= DATA_LAST) rxsh <= {rxsh[6:0], sdo};
          if (cnt == STAT_BIT) stat <= sdo;
          if (cnt == CLOSE_BIT) begin
            cs_n <= 1'b1; sdi <= 1'b1; cnt <= GAP_BIT;
          end else if (cnt == GAP_BIT) begin
            if (!stat) begin
              busy <= 1'b0; done <= 1'b1;
              if (is_rd) rd_data <= rxsh;
            end else if (retry_max != '0 && retries == retry_max) begin
              busy <= 1'b0; done <= 1'b1; done_err <= 1'b1;
            end else begin
              retries <= retries + 1'b1;
              cnt <= '0; cs_n <= 1'b0; sdi <= 1'b1;
            end
          end else begin
            cnt <= cnt + 4'd1;
            sdi <= bit_for(cnt + 4'd1, is_rd, wbyte);
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_retry_master_chk.sv
module spi_retry_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic done_err,
  input logic sclk,
  input logic cs_n,
  input logic sdi
);
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sdi);
  assert_sdi_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdi) |-> !sclk);
  assert_busy_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n || sclk) |-> !req_ready);
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !sclk && req_ready));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind spi_retry_master spi_retry_master_chk chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .done_err(done_err), .sclk(sclk), .cs_n(cs_n), .sdi(sdi)
);

// File: tb/spi_retry_master_test.sv
module spi_retry_master_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] clk_div = '0;
  logic [3:0] retry_max = '0;
  logic       req_valid = 1'b0, req_read = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, done, done_err, sclk, cs_n, sdi;
  logic [7:0] rd_data;
  logic       sdo = 1'b1;

  int total = 0, bad = 0;

  spi_retry_master uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .retry_max(retry_max),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_wdata(req_wdata), .done(done), .done_err(done_err), .rd_data(rd_data),
    .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave model
  int         sb = 0, frames = 0, tx_frames = 0, rej_left = 0;
  bit         gap_seen = 1'b1, cur_bad = 1'b0;
  bit         f_start, f_dir, f_sel;
  logic [7:0] f_data = '0, fresh = '0, got = '0;
  bit         exp_rd = 1'b0;
  logic [7:0] exp_byte = '0;

  always @(negedge cs_n) begin
    if (rst_n) begin
      chk(gap_seen, "R8 gap edge before frame", int'(gap_seen), 1);
      gap_seen = 1'b0;
      sb = 0;
      frames++; tx_frames++;
      cur_bad = (rej_left > 0);
      if (cur_bad) rej_left--;
    end
  end

  always @(posedge sclk) begin
    if (cs_n) begin
      if (sdi) gap_seen = 1'b1;
    end else begin
      if (sb == 0) f_start = sdi;
      else if (sb == 1) f_dir = sdi;
      else if (sb == 2) f_sel = sdi;
      else if (sb <= 10) f_data = {f_data[6:0], sdi};
      if (sb >= 3 && sb <= 10)
        sdo = cur_bad ? ~fresh[10-sb] : fresh[10-sb];
      else if (sb == 11)
        sdo = cur_bad;
      else
        sdo = 1'b1;
      sb++;
    end
  end

  always @(posedge cs_n) begin
    if (rst_n) begin
      chk(sb == 13, "R2 rising edges per frame", sb, 13);
      chk(f_start && f_dir == exp_rd && !f_sel, "R2 start/dir/select bits",
          {f_start, f_dir, f_sel}, {1'b1, exp_rd, 1'b0});
      if (!exp_rd) begin
        chk(f_data == exp_byte, "R5 write frame content", f_data, exp_byte);
        if (!cur_bad) got = f_data;
      end
    end
  end

  task automatic run(input bit rd, input logic [7:0] b, input int dv, input int rm, input int rej);
    int n, fr, expn;
    bit drop;
    logic [7:0] prev;
    @(negedge clk);
    clk_div = 8'(dv); retry_max = 4'(rm);
    rej_left = rej; tx_frames = 0; exp_rd = rd; exp_byte = b;
    fresh = rd ? b : 8'h5A;
    got = ~b;
    prev = rd_data;
    chk(req_ready, "R10 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_read = rd; req_wdata = b;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready low after accept", int'(req_ready), 0);
    n = 0;
    while (!done && n < 60000) begin
      @(posedge clk); n++; #1;
    end
    drop = (rm != 0) && (rej > rm);
    fr = drop ? rm + 1 : rej + 1;
    expn = 28 * fr * (dv + 1);
    chk(n == expn, "R11 R3 completion latency", n, expn);
    chk(done_err == drop, drop ? "R9 error on limit" : "R6 no error on accept",
        int'(done_err), int'(drop));
    chk(tx_frames == fr, rd ? "R7 read frame count" : "R5 write frame count", tx_frames, fr);
    if (rd) begin
      if (drop) chk(rd_data == prev, "R7 stale byte not delivered", rd_data, prev);
      else chk(rd_data == b, "R7 R4 fresh byte delivered", rd_data, b);
    end else if (!drop) begin
      chk(got == b, "R6 accepted byte", got, b);
    end
    @(posedge clk); #1;
    chk(!done, "R6 done is a pulse", int'(done), 0);
    repeat (2 * (dv + 1) * 4) @(posedge clk);
    #1;
    chk(tx_frames == fr && cs_n, "R9 no frame after completion", tx_frames, fr);
  endtask

  initial begin
    #(CLK_P * 195000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n && sdi && !sclk && req_ready && !done, "R1 reset state",
        {cs_n, sdi, sclk, req_ready, done}, 5'b11010);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(cs_n && sdi && !sclk && req_ready && !done, "R1 state after reset release",
        {cs_n, sdi, sclk, req_ready, done}, 5'b11010);
    for (int d = 0; d < 3; d++)
      for (int m = 0; m < 2; m++)
        for (int rj = 0; rj < 4; rj++)
          for (int r = 0; r < 2; r++)
            run(r[0], 8'(8'hA5 ^ (d * 37 + rj * 11 + r * 73 + m * 5)),
                (d == 2) ? 3 : d, m * 2, rj);
    run(1'b0, 8'h00, 0, 0, 6);
    run(1'b1, 8'hFF, 1, 3, 3);
    run(1'b1, 8'h81, 0, 1, 2);
    run(1'b0, 8'h3C, 0, 1, 2);
    run(1'b1, 8'h7E, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule